// File: doc/BRIEF.md
# Oldest-First Multi-Class Issue Selector

This block sits at the issue stage of an out-of-order core. Ready instructions wait in separate queues, one per operation class, and every queue presents only its head: the entry with the smallest sequence number. In each cycle the selector ranks the class heads by age and walks them from oldest to youngest. It grants up to `ISSUE_W` of them. A head that has been squashed is thrown away without using any issue slot. A class whose functional unit is occupied is passed over, and the walk goes on to younger classes. Each pass-over adds one to a running busy counter.

The selector also keeps track of which functional units are occupied. A unit that is pipelined, or that has a latency of one cycle, can accept new work in the next cycle. A unit that is not pipelined and has a latency above one stays occupied until its operation completes. An issued instruction that does not access memory frees its queue entry in the same cycle. A memory instruction keeps its entry until the memory side reports that it has finished. One class, or a set of classes chosen by a parameter mask, needs no unit and issues whenever the walk reaches it.

Top module: `oldest_issue_sel`

## Requirements
- R1: After reset `busy_cnt` is 0 and no unit is held. With no valid head, `grant` is 0, `issue_cnt` is 0 and `no_issue` is 1.
- R2: The granted set is the `ISSUE_W` oldest eligible heads, oldest meaning smallest unsigned sequence number. A head is eligible when it is valid, not squashed and its unit is usable. `issue_cnt` equals the number of bits set in `grant`.
- R3: When two heads have equal sequence numbers, the class with the lower index counts as older.
- R4: A valid squashed head is reached when fewer than `ISSUE_W` eligible heads are older than it. A reached squashed head is signalled on `drop`, is never granted and uses no issue slot. A squashed head that is not reached does not assert `drop`.
- R5: A valid, unsquashed head whose unit is unusable is not granted. Younger eligible heads are still granted. If such a head is reached, `busy_cnt` goes up by one at the next clock edge. A unit is unusable when `fu_free` is low or the unit is held.
- R6: A class in `NO_UNIT_MASK` (class 0 by default) issues when reached, whatever its `fu_free` bit says, and never asserts `fu_req`.
- R7: `fu_req[c]` is high exactly when class c is granted and c is not in `NO_UNIT_MASK`.
- R8: Suppose class c issues in cycle t with `fu_pipe[c]`=0 and latency L>1. Then c cannot be granted in cycles t+1 to t+L-1 and can be granted again in cycle t+L. With `fu_pipe[c]`=1 or L≤1, c can be granted again in cycle t+1.
- R9: `entry_rel[c]` is high when class c is granted with `head_mem[c]`=0, or when `mem_done[c]` is high. A granted head with `head_mem[c]`=1 does not raise it.
- R10: `no_issue` is high exactly when `issue_cnt` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; released synchronously inside the block |
| head_vld | input | NUM_CLASS | Class head is present |
| head_seq | input | NUM_CLASS*SEQ_W | Sequence number of each class head; class c is at bits c*SEQ_W upward |
| head_sqsh | input | NUM_CLASS | Class head has been squashed |
| head_mem | input | NUM_CLASS | Class head is a memory instruction |
| mem_done | input | NUM_CLASS | A memory instruction of this class has finished; its entry may be freed |
| fu_free | input | NUM_CLASS | Functional unit of the class is available from outside |
| fu_lat | input | NUM_CLASS*LAT_W | Issue latency of each class unit in cycles |
| fu_pipe | input | NUM_CLASS | Class unit is pipelined |
| grant | output | NUM_CLASS | Head of the class is issued this cycle |
| drop | output | NUM_CLASS | Squashed head of the class is discarded this cycle |
| fu_req | output | NUM_CLASS | Functional unit of the class is claimed this cycle |
| entry_rel | output | NUM_CLASS | One queue entry of the class is freed this cycle |
| issue_cnt | output | $clog2(ISSUE_W+1) | Number of grants this cycle |
| no_issue | output | 1 | Nothing was issued this cycle |
| busy_cnt | output | BCNT_W | Running count of reached heads passed over because their unit was busy |

## Verification
The bench uses the default build: four classes, two issue slots, 8-bit sequence numbers and 4-bit latencies, with class 0 as the no-unit class. Four classes against two slots give enough pressure that the width limit cuts the walk off. This makes it possible to drive a squashed or busy head that lies beyond the cut, next to one that is reached. A 4-bit latency lets a latency-3 unit that is not pipelined be held for two cycles and then granted again on the exact cycle it frees. The same class with the pipelined bit set can be granted back to back.

// File: rtl/oisel_pkg.sv
package oisel_pkg;

  // True when head (sa, ia) is older than head (sb, ib): the smaller
  // sequence number wins, and on equal numbers the lower class index wins.
  function automatic logic age_before(input logic [63:0] sa, input int ia,
                                      input logic [63:0] sb, input int ib);
    return (sa < sb) || ((sa == sb) && (ia < ib));
  endfunction

endpackage

// File: rtl/oisel_age_rank.sv
module oisel_age_rank #(
  parameter int NUM_CLASS = 4,
  parameter int SEQ_W     = 8,
  parameter int CW        = $clog2(NUM_CLASS + 1)
) (
  input  logic [NUM_CLASS*SEQ_W-1:0] seq,
  input  logic [NUM_CLASS-1:0]       elig,
  output logic [NUM_CLASS*CW-1:0]    older_cnt
);
  import oisel_pkg::*;

  // For every class, count the eligible heads that are older than its head.
  for (genvar c = 0; c < NUM_CLASS; c++) begin : g_rank
    logic [CW-1:0] cnt;
    always_comb begin
      cnt = '0;
      for (int j = 0; j < NUM_CLASS; j++) begin
        if (j != c && elig[j] &&
            age_before(64'(seq[j*SEQ_W +: SEQ_W]), j,
                       64'(seq[c*SEQ_W +: SEQ_W]), c))
          cnt = cnt + CW'(1);
      end
    end
    assign older_cnt[c*CW +: CW] = cnt;
  end

endmodule

// File: rtl/oisel_unit_hold.sv
module oisel_unit_hold #(
  parameter int NUM_CLASS = 4,
  parameter int LAT_W     = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_CLASS-1:0]       issue,
  input  logic [NUM_CLASS*LAT_W-1:0] lat,
  input  logic [NUM_CLASS-1:0]       pipe,
  output logic [NUM_CLASS-1:0]       held
);

  for (genvar c = 0; c < NUM_CLASS; c++) begin : g_unit
    logic [LAT_W-1:0] lat_c;
    logic [LAT_W-1:0] cnt_q, cnt_d;
    logic             load, cnt_en;

    assign lat_c  = lat[c*LAT_W +: LAT_W];
    assign load   = issue[c] && !pipe[c] && (lat_c > LAT_W'(1));
    assign cnt_en = load || (cnt_q != '0);

    always_comb begin
      cnt_d = cnt_q;
      if (load)
        cnt_d = lat_c - LAT_W'(1);
      else if (cnt_q != '0)
        cnt_d = cnt_q - LAT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        cnt_q <= '0;
      else if (cnt_en)
        cnt_q <= cnt_d;
    end

    assign held[c] = (cnt_q != '0);

    // R8: an issue to a unit that is not pipelined and has a long latency holds the unit
    assert_hold_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> held[c]);
  end

endmodule

// File: rtl/oldest_issue_sel.sv
module oldest_issue_sel #(
  parameter int                 NUM_CLASS    = 4,
  parameter int                 ISSUE_W      = 2,
  parameter int                 SEQ_W        = 8,
  parameter int                 LAT_W        = 4,
  parameter int                 BCNT_W       = 16,
  parameter logic [NUM_CLASS-1:0] NO_UNIT_MASK = NUM_CLASS'(1)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NUM_CLASS-1:0]           head_vld,
  input  logic [NUM_CLASS*SEQ_W-1:0]     head_seq,
  input  logic [NUM_CLASS-1:0]           head_sqsh,
  input  logic [NUM_CLASS-1:0]           head_mem,
  input  logic [NUM_CLASS-1:0]           mem_done,
  input  logic [NUM_CLASS-1:0]           fu_free,
  input  logic [NUM_CLASS*LAT_W-1:0]     fu_lat,
  input  logic [NUM_CLASS-1:0]           fu_pipe,
  output logic [NUM_CLASS-1:0]           grant,
  output logic [NUM_CLASS-1:0]           drop,
  output logic [NUM_CLASS-1:0]           fu_req,
  output logic [NUM_CLASS-1:0]           entry_rel,
  output logic [$clog2(ISSUE_W+1)-1:0]   issue_cnt,
  output logic                           no_issue,
  output logic [BCNT_W-1:0]              busy_cnt
);
  localparam int CW  = $clog2(NUM_CLASS + 1);
  localparam int IW  = $clog2(ISSUE_W + 1);
  localparam int SKW = $clog2(NUM_CLASS + 1);

  // Reset: asserted asynchronously, released on a clock edge
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  // Unit availability
  logic [NUM_CLASS-1:0] held, unit_ok, elig, reached, skip;
  assign unit_ok = NO_UNIT_MASK | (fu_free & ~held);
  assign elig    = head_vld & ~head_sqsh & unit_ok;

  // Age ranking among eligible heads
  logic [NUM_CLASS*CW-1:0] older_cnt;
  oisel_age_rank #(.NUM_CLASS(NUM_CLASS), .SEQ_W(SEQ_W), .CW(CW)) u_rank (
    .seq       (head_seq),
    .elig      (elig),
    .older_cnt (older_cnt)
  );

  for (genvar c = 0; c < NUM_CLASS; c++) begin : g_reach
    assign reached[c] = (older_cnt[c*CW +: CW] < CW'(ISSUE_W));
  end

  assign grant     = elig & reached;
  assign drop      = head_vld & head_sqsh & reached;
  assign skip      = head_vld & ~head_sqsh & ~unit_ok & reached;
  assign fu_req    = grant & ~NO_UNIT_MASK;
  assign entry_rel = (grant & ~head_mem) | mem_done;

  // Unit occupancy tracking
  oisel_unit_hold #(.NUM_CLASS(NUM_CLASS), .LAT_W(LAT_W)) u_hold (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .issue (fu_req),
    .lat   (fu_lat),
    .pipe  (fu_pipe),
    .held  (held)
  );

  // Per-cycle counts
  logic [SKW-1:0] skip_n;
  always_comb begin
    issue_cnt = '0;
    skip_n    = '0;
    for (int c = 0; c < NUM_CLASS; c++) begin
      issue_cnt = issue_cnt + IW'(grant[c]);
      skip_n    = skip_n + SKW'(skip[c]);
    end
  end
  assign no_issue = (issue_cnt == '0);

  // Busy event counter
  logic [BCNT_W-1:0] busy_q, busy_d;
  logic              busy_en;
  assign busy_en = |skip;
  assign busy_d  = busy_q + BCNT_W'(skip_n);

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)
      busy_q <= '0;
    else if (busy_en)
      busy_q <= busy_d;
  end
  assign busy_cnt = busy_q;

  // R2: never more grants than the issue width
  assert_width_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $countones(grant) <= ISSUE_W);

  // R10: the no-issue flag agrees with the grant vector
  assert_quiet_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    no_issue |-> (grant == '0));

  // R5: a class that needs a unit is granted only when that unit is usable
  for (genvar c = 0; c < NUM_CLASS; c++) begin : g_chk
    if (!NO_UNIT_MASK[c]) begin : g_unit_cls
      assert_unit_ok_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
        grant[c] |-> (fu_free[c] && !held[c]));
    end
  end

endmodule

// File: tb/test_oldest_issue_sel.sv
`timescale 1ns/1ps
module test_oldest_issue_sel;
  localparam int C = 4;
  localparam int W = 2;
  localparam int SW = 8;
  localparam int LW = 4;
  localparam int BW = 16;

  logic clk = 1'b0;
  logic rst_n;
  logic [C-1:0]    head_vld, head_sqsh, head_mem, mem_done, fu_free, fu_pipe;
  logic [C*SW-1:0] head_seq;
  logic [C*LW-1:0] fu_lat;
  logic [C-1:0]    grant, drop, fu_req, entry_rel;
  logic [1:0]      issue_cnt;
  logic            no_issue;
  logic [BW-1:0]   busy_cnt;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  oldest_issue_sel #(.NUM_CLASS(C), .ISSUE_W(W), .SEQ_W(SW), .LAT_W(LW),
                     .BCNT_W(BW)) i_oldest_issue_sel (
    .clk(clk), .rst_n(rst_n), .head_vld(head_vld), .head_seq(head_seq),
    .head_sqsh(head_sqsh), .head_mem(head_mem), .mem_done(mem_done),
    .fu_free(fu_free), .fu_lat(fu_lat), .fu_pipe(fu_pipe), .grant(grant),
    .drop(drop), .fu_req(fu_req), .entry_rel(entry_rel),
    .issue_cnt(issue_cnt), .no_issue(no_issue), .busy_cnt(busy_cnt));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic defaults();
    head_vld = '0; head_sqsh = '0; head_mem = '0; mem_done = '0;
    fu_free = '1; fu_pipe = '1; head_seq = '0;
    for (int c = 0; c < C; c++) fu_lat[c*LW +: LW] = 4'd1;
  endtask

  task automatic seqs(input logic [7:0] s0, s1, s2, s3);
    head_seq = {s3, s2, s1, s0};
  endtask

  task automatic t_reset();
    defaults();
    #1;
    chk("R1 busy_cnt", 32'(busy_cnt), 0);
    chk("R1 grant", 32'(grant), 0);
    chk("R1 issue_cnt", 32'(issue_cnt), 0);
    chk("R1 no_issue", 32'(no_issue), 1);
  endtask

  task automatic t_oldest();
    defaults(); head_vld = 4'b1111; seqs(40, 10, 30, 20);
    #1;
    chk("R2 grant oldest two", 32'(grant), 32'b1010);
    chk("R2 issue_cnt", 32'(issue_cnt), 2);
    chk("R7 fu_req", 32'(fu_req), 32'b1010);
    chk("R9 entry_rel non-mem", 32'(entry_rel), 32'b1010);
    chk("R10 no_issue low", 32'(no_issue), 0);
    seqs(3, 200, 7, 250);
    #1;
    chk("R2 grant second pattern", 32'(grant), 32'b0101);
    chk("R7 fu_req excludes class 0", 32'(fu_req), 32'b0100);
    tick();
  endtask

  task automatic t_tie();
    defaults(); head_vld = 4'b1111; seqs(5, 5, 5, 9);
    #1;
    chk("R3 tie lower index", 32'(grant), 32'b0011);
    seqs(9, 6, 6, 6);
    #1;
    chk("R3 tie among 1..3", 32'(grant), 32'b0110);
    tick();
  endtask

  task automatic t_squash();
    defaults(); head_vld = 4'b1111; seqs(1, 2, 3, 4); head_sqsh = 4'b0011;
    #1;
    chk("R4 drop reached", 32'(drop), 32'b0011);
    chk("R4 grant past squashed", 32'(grant), 32'b1100);
    chk("R4 issue_cnt", 32'(issue_cnt), 2);
    seqs(1, 2, 9, 4); head_sqsh = 4'b0100;
    #1;
    chk("R4 unreached squash kept", 32'(drop), 32'b0000);
    chk("R4 grant", 32'(grant), 32'b0011);
    tick();
  endtask

  task automatic t_busy();
    logic [BW-1:0] b0;
    defaults(); head_vld = 4'b1111; seqs(1, 2, 3, 4); fu_free = 4'b1101;
    #1;
    chk("R5 skip busy class", 32'(grant), 32'b0101);
    b0 = busy_cnt;
    tick();
    chk("R5 busy_cnt +1", 32'(busy_cnt - b0), 1);
    fu_free = 4'b0000;
    #1;
    chk("R6 no-unit class issues", 32'(grant), 32'b0001);
    chk("R6 no fu_req", 32'(fu_req), 0);
    b0 = busy_cnt;
    tick();
    chk("R5 busy_cnt +3", 32'(busy_cnt - b0), 3);
    head_vld = 4'b1110;
    #1;
    chk("R10 no_issue", 32'(no_issue), 1);
    chk("R10 issue_cnt", 32'(issue_cnt), 0);
    tick();
  endtask

  task automatic t_hold();
    defaults(); head_vld = 4'b0100; seqs(0, 0, 1, 0);
    fu_lat[2*LW +: LW] = 4'd3; fu_pipe[2] = 1'b0;
    #1;
    chk("R8 first issue", 32'(grant), 32'b0100);
    tick();
    chk("R8 held t+1", 32'(grant), 0);
    tick();
    chk("R8 held t+2", 32'(grant), 0);
    tick();
    chk("R8 free t+3", 32'(grant), 32'b0100);
    fu_pipe[2] = 1'b1;
    #1;
    tick();
    chk("R8 pipelined next cycle", 32'(grant), 32'b0100);
    fu_pipe[2] = 1'b0; fu_lat[2*LW +: LW] = 4'd1;
    #1;
    tick();
    chk("R8 single-cycle next cycle", 32'(grant), 32'b0100);
    tick();
  endtask

  task automatic t_mem();
    defaults(); head_vld = 4'b0010; seqs(0, 7, 0, 0); head_mem = 4'b0010;
    #1;
    chk("R9 mem granted", 32'(grant), 32'b0010);
    chk("R9 mem keeps entry", 32'(entry_rel), 0);
    mem_done = 4'b0010;
    #1;
    chk("R9 mem_done frees", 32'(entry_rel), 32'b0010);
    head_vld = 4'b0000; mem_done = 4'b1000;
    #1;
    chk("R9 mem_done alone", 32'(entry_rel), 32'b1000);
    tick();
  endtask

  initial begin
    #500000;
    n_bad++;
    $display("FAIL watchdog act=running exp=done");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    defaults();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) tick();
    t_reset();
    t_oldest();
    t_tie();
    t_squash();
    t_busy();
    t_hold();
    t_mem();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule